// File: doc/BRIEF.md
# Memory Parity Error Capture Register

This block sits next to a 32-bit memory data path that stores one parity bit per byte lane. On the write side it computes odd parity for each of the four lanes, so the memory can store it beside the data. On the read side it checks every returned word against its stored parity bits. The first failing read is captured: the set of failing lanes and the access address. That capture is then held against all later errors until software clears it.

A CPU sees two locations through a small register port. The control/status byte sits at byte offset 0 and the captured address word sits at byte offset 4. The status byte carries a pending flag, an interrupt enable, a test bit and a check enable, plus one error flag per lane. The interrupt is the pending flag gated by the enable bit. The test bit makes every write store inverted parity, so that error handling can be exercised end to end.

Neither memory-side path is a back-pressured stream. The write path is purely combinational. The read check accepts a word on every cycle that `rd_valid` is high and never stalls the memory, so the block has no ready output.

Top module: `mem_parity_guard`

## Requirements
- R1: After reset, the status byte and the captured address both read as zero, and `irq` is low.
- R2: For each lane i (data bits 8i+7 down to 8i), `wr_par[i]` is chosen so that the lane byte plus that bit holds an odd number of ones.
- R3: While the test bit (status bit 5) is set, each of the four `wr_par` bits is the inverse of the R2 value.
- R4: A read word is checked only when `rd_valid` is high and the check-enable bit (status bit 4) is set. A lane fails when its byte plus its parity bit holds an even number of ones. With checking disabled, nothing is recorded.
- R5: On the first failing read, the failing lanes and `rd_addr` are captured on the next clock edge. Flag bit i (bits 3..0) marks lane i, and the pending bit (bit 7) reads 1 whenever any flag is set.
- R6: While an error is held, later failing reads change neither the flags nor the captured address.
- R7: A register write at offset 0 loads bits 6, 5 and 4 from `reg_wdata` and clears all flags and the pending bit. If an error arrives in the same cycle, the write wins and that error is dropped.
- R8: `irq` is high exactly when the pending bit and the interrupt-enable bit (bit 6) are both set, with no extra register stage.
- R9: Reads at offset 0 return the status byte in bits 7..0 with the upper bits zero. Offset 4 returns the captured address, and every other offset returns zero. Writes at any offset other than 0 have no effect.
- R10: When several lanes fail on the same read, all of their flags are set in the same cycle as the address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 32 | Data word being written to memory |
| wr_par | output | 4 | Parity bits to store with `wr_data`, one per lane |
| rd_valid | input | 1 | A read word is present this cycle |
| rd_addr | input | 32 | Address of the read access |
| rd_data | input | 32 | Data word returned by memory |
| rd_par | input | 4 | Stored parity bits returned with `rd_data` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Memory error interrupt |

## Verification
The bench drives a read that fails in two lanes at once. A design that latched the lanes one at a time, or a cycle after the address, would show a partial flag set or a stale address. It then sends a second error with a different address and lane set. A capture that was not frozen would overwrite the first record and lose it. It also places a status write in the same cycle as a failing read; a design that gave the error priority would come back pending with the interrupt raised. Further checks cover the test bit inverting all four parity bits, reads with checking disabled, and writes to the address offset. A design that computed even parity, ignored the enable, or decoded writes too loosely would visibly disturb `wr_par` or the status byte.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LANES    = 4;
  localparam int unsigned DATA_W   = LANES * BYTE_W;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned OFS_W    = 3;
  // Status byte layout; software decodes these positions.
  localparam int unsigned BIT_PEND = 7;
  localparam int unsigned BIT_IEN  = 6;
  localparam int unsigned BIT_TEST = 5;
  localparam int unsigned BIT_CHK  = 4;
  localparam logic [OFS_W-1:0] OFS_CSR  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_ADDR = 3'd4;

  typedef struct packed {
    logic ien;
    logic test;
    logic chk;
  } mpg_ctrl_t;
endpackage

// File: rtl/mpg_par_gen.sv
module mpg_par_gen
  import mpg_pkg::*;
#(
  parameter int unsigned N_LANES = LANES
) (
  input  logic [N_LANES*BYTE_W-1:0] data,
  input  logic                      invert,
  output logic [N_LANES-1:0]        par
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    // Odd parity: set the bit when the byte holds an even count of ones.
    assign par[g] = ~(^data[g*BYTE_W +: BYTE_W]) ^ invert;
  end
endmodule

// File: rtl/mpg_par_chk.sv
module mpg_par_chk
  import mpg_pkg::*;
#(
  parameter int unsigned N_LANES = LANES
) (
  input  logic                      valid,
  input  logic                      enable,
  input  logic [N_LANES*BYTE_W-1:0] data,
  input  logic [N_LANES-1:0]        par,
  output logic [N_LANES-1:0]        bad
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign bad[g] = valid & enable & ~(^{par[g], data[g*BYTE_W +: BYTE_W]});
  end
endmodule

// File: rtl/mpg_capture.sv
module mpg_capture
  import mpg_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  parameter int unsigned A_W     = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_wr,
  input  mpg_ctrl_t          ctrl_d,
  input  logic [N_LANES-1:0] bad,
  input  logic [A_W-1:0]     addr,
  output mpg_ctrl_t          ctrl_q,
  output logic [N_LANES-1:0] flags_q,
  output logic [A_W-1:0]     addr_q
);
  logic held;
  assign held = |flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      addr_q  <= '0;
    end else if (csr_wr) begin
      ctrl_q  <= ctrl_d;
      flags_q <= '0;
    end else if (!held && (|bad)) begin
      flags_q <= bad;
      addr_q  <= addr;
    end
  end
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_par,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  rd_par,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  mpg_ctrl_t         ctrl_q, ctrl_d;
  logic [LANES-1:0]  bad, flags_q;
  logic [ADDR_W-1:0] addr_q;
  logic              csr_wr, pending;
  logic              ctl_ien, ctl_test, ctl_chk;
  logic [7:0]        csr_byte;

  assign csr_wr      = reg_wr && (reg_addr == OFS_CSR);
  assign ctrl_d.ien  = reg_wdata[BIT_IEN];
  assign ctrl_d.test = reg_wdata[BIT_TEST];
  assign ctrl_d.chk  = reg_wdata[BIT_CHK];
  assign ctl_ien     = ctrl_q.ien;
  assign ctl_test    = ctrl_q.test;
  assign ctl_chk     = ctrl_q.chk;

  mpg_par_gen #(.N_LANES(LANES)) u_gen (
    .data(wr_data), .invert(ctl_test), .par(wr_par)
  );

  mpg_par_chk #(.N_LANES(LANES)) u_chk (
    .valid(rd_valid), .enable(ctl_chk), .data(rd_data), .par(rd_par), .bad(bad)
  );

  mpg_capture #(.N_LANES(LANES), .A_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .ctrl_d(ctrl_d),
    .bad(bad), .addr(rd_addr),
    .ctrl_q(ctrl_q), .flags_q(flags_q), .addr_q(addr_q)
  );

  assign pending  = |flags_q;
  assign csr_byte = {pending, ctl_ien, ctl_test, ctl_chk, flags_q};
  assign irq      = pending & ctl_ien;

  always_comb begin
    unique case (reg_addr)
      OFS_CSR:  reg_rdata = {24'b0, csr_byte};
      OFS_ADDR: reg_rdata = addr_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mpg_checker.sv
module mpg_checker
  import mpg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [LANES-1:0]  rd_par,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              reg_wr,
  input logic [OFS_W-1:0]  reg_addr,
  input logic [LANES-1:0]  flags,
  input logic [ADDR_W-1:0] cap_addr,
  input logic              ien,
  input logic              chk,
  input logic              irq
);
  logic             wr0;
  logic [LANES-1:0] even_lane;
  assign wr0 = reg_wr && (reg_addr == 3'd0);
  always_comb
    for (int i = 0; i < LANES; i++)
      even_lane[i] = ($countones({rd_par[i], rd_data[i*BYTE_W +: BYTE_W]}) % 2) == 0;

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && chk && flags == '0 && !wr0 && even_lane != '0)
      |=> (flags != '0) && (cap_addr == $past(rd_addr)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0 && !wr0) |=> $stable(flags) && $stable(cap_addr));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> flags == '0);

  a_r4_no_check: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk && flags == '0) |=> flags == '0);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
endmodule

bind mem_parity_guard mpg_checker u_mpg_checker (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_par(rd_par), .rd_addr(rd_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .flags(flags_q), .cap_addr(addr_q), .ien(ctl_ien), .chk(ctl_chk), .irq(irq)
);

// File: tb/tb_mem_parity_guard.sv
module tb_mem_parity_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_par;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [31:0] rd_data = '0;
  logic [3:0]  rd_par = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  bit m_ien, m_test, m_chk;
  bit [3:0] m_flags;
  bit [31:0] m_addr;

  always #10 clk = ~clk;

  mem_parity_guard dut (.*);

  function automatic bit [3:0] odd_par(input bit [31:0] d);
    bit [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ($countones(d[i*8 +: 8]) % 2) == 0;
    return p;
  endfunction

  task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] exp_rdata();
    case (reg_addr)
      3'd0: return {24'b0, (m_flags != 0), m_ien, m_test, m_chk, m_flags};
      3'd4: return m_addr;
      default: return 32'b0;
    endcase
  endfunction

  task automatic model_update();
    bit [3:0] bad;
    if (!rst_n) begin
      m_ien = 0; m_test = 0; m_chk = 0; m_flags = 0; m_addr = 0;
    end else if (reg_wr && reg_addr == 3'd0) begin
      m_ien = reg_wdata[6]; m_test = reg_wdata[5]; m_chk = reg_wdata[4];
      m_flags = 0;
    end else if (rd_valid && m_chk && m_flags == 0) begin
      for (int i = 0; i < 4; i++)
        bad[i] = (($countones(rd_data[i*8 +: 8]) + rd_par[i]) % 2) == 0;
      if (bad != 0) begin m_flags = bad; m_addr = rd_addr; end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check("R2 R3 wr_par", wr_par, odd_par(wr_data) ^ {4{m_test}});
    check("R9 reg_rdata", reg_rdata, exp_rdata());
    check("R8 irq", irq, (m_flags != 0) && m_ien);
    reg_wr = 0; rd_valid = 0;
  endtask

  task automatic csr_write(input bit [7:0] v);
    reg_wr = 1; reg_addr = 3'd0; reg_wdata = v; step();
  endtask

  task automatic bad_read(input bit [31:0] a, input bit [31:0] d, input bit [3:0] flip);
    rd_valid = 1; rd_addr = a; rd_data = d; rd_par = odd_par(d) ^ flip; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    reg_addr = 3'd0; #1;
    check("R1 csr after reset", reg_rdata, 32'h0);
    check("R1 irq after reset", irq, 0);
    reg_addr = 3'd4; #1;
    check("R1 addr after reset", reg_rdata, 32'h0);
    @(negedge clk); rst_n = 1; step();

    wr_data = 32'h0000_0001; #1;
    check("R2 odd parity", wr_par, 4'b1110);
    csr_write(8'h70); wr_data = 32'h0000_0001; #1;
    check("R3 test inverts", wr_par, 4'b0001);

    csr_write(8'h50);
    bad_read(32'h1234_5678, 32'h01FF_0300, 4'b1010);
    reg_addr = 3'd0; #1;
    check("R5 R10 two lanes captured", reg_rdata, 32'h0000_00DA);
    check("R8 irq raised", irq, 1);
    reg_addr = 3'd4; #1;
    check("R5 address captured", reg_rdata, 32'h1234_5678);

    bad_read(32'hCAFE_0000, 32'h0, 4'b0001);
    reg_addr = 3'd4; #1;
    check("R6 address held", reg_rdata, 32'h1234_5678);
    reg_addr = 3'd0; #1;
    check("R6 flags held", reg_rdata, 32'h0000_00DA);

    reg_wr = 1; reg_addr = 3'd4; reg_wdata = 8'hFF; step();
    reg_addr = 3'd0; #1;
    check("R9 write at offset 4 ignored", reg_rdata, 32'h0000_00DA);

    rd_valid = 1; rd_addr = 32'h0BAD_0000; rd_data = 32'h0; rd_par = 4'b0000;
    csr_write(8'h50);
    reg_addr = 3'd0; #1;
    check("R7 write beats error", reg_rdata, 32'h0000_0050);
    check("R7 irq low after clear", irq, 0);

    csr_write(8'h40);
    bad_read(32'h0000_0040, 32'hFFFF_FFFF, 4'b1111);
    reg_addr = 3'd0; #1;
    check("R4 disabled check records nothing", reg_rdata, 32'h0000_0040);

    for (int n = 0; n < 3000; n++) begin
      wr_data = $urandom;
      rd_valid = $urandom_range(0, 1);
      rd_addr = $urandom;
      rd_data = $urandom;
      rd_par = odd_par(rd_data) ^ (($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0);
      reg_wr = ($urandom_range(0, 15) == 0);
      case ($urandom_range(0, 3))
        0: reg_addr = 3'd0;
        1: reg_addr = 3'd4;
        2: reg_addr = 3'd1;
        default: reg_addr = 3'($urandom);
      endcase
      reg_wdata = $urandom;
      if (reg_wr && reg_addr == 3'd0) reg_wdata[4] = 1'b1;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule